// File: doc/BRIEF.md
# MMU Fault Classifier and Vector Select

This block sits beside the address translation stage of a processor core and decides, for every memory access, whether the access may proceed or must trap. Each request carries a 32-bit virtual address, the access kind, the privilege mode, a flag for a misaligned access, and the result of a TLB lookup made elsewhere (hit plus read, write and execute rights). It also receives a flag telling whether an MMU is fitted and the current exception-handling bit of the status word.

One cycle after a request strobe, the block returns its verdict:
- whether the access is allowed;
- whether the address maps one-to-one and bypasses the TLB;
- a cause code;
- the fault-status bits that the trap entry logic must set;
- whether the trap goes to the fast TLB-miss vector or to the general exception vector.

On a fault, a bad-address register and a page-table-address virtual page number register are loaded for software to read in the handler.

The TLB storage and its lookup are outside this block. Pages are 4 KB, so the virtual page number is the address shifted right by twelve.

Top module: `mmu_fault_sel`

## Requirements
- R1: While reset is active, and after it is released with no request, all outputs are zero.
- R2: Each cycle with `req_valid` high produces `rsp_valid` high on the next clock edge, carrying that request's results. A cycle without a request produces `rsp_valid` low.
- R3: With `mmu_en` low, a correctly aligned access is allowed with `rsp_bypass` = 1, cause 0 and no status bits.
- R4: In supervisor mode (`req_user` = 0), an aligned access at or above 0xC0000000 is allowed with `rsp_bypass` = 1, whatever the TLB result.
- R5: In user mode, an aligned access at or above 0x80000000 faults on the general vector:
  - cause 6 for a fetch and cause 7 for a load or store;
  - status BAD, plus D for a load or store.
- R6: On a TLB hit, a load needs read rights, a store needs write rights and a fetch needs execute rights. Without them the access faults on the general vector:
  - cause 3 (load), 4 (store) or 5 (fetch);
  - status PERM, plus D for a load or store, plus WE only when EH is 0.
- R7: A TLB miss gives cause 1 for a fetch and cause 2 for a load or store, with D for a load or store.
  - With EH = 0, WE is added and `rsp_fast` = 1.
  - With EH = 1, DBL is added and `rsp_fast` = 0.
- R8: Which registers a fault loads depends on its kind:
  - a TLB miss or a permission fault loads `bad_addr` with the full address and `pte_vpn` with address >> 12;
  - any other fault loads only `bad_addr`;
  - an allowed access changes neither register.
- R9: A misaligned access (`req_misal` = 1) takes priority over every other check. It faults with cause 8 and status BAD, plus D for a load or store, on the general vector.
- R10: A TLB hit with the needed right, outside the bypass and protected windows, is allowed with `rsp_bypass` = 0, cause 0, no status bits and `rsp_fast` = 0.
- R11: Cycles without a request leave `rsp_ok`, `rsp_bypass`, `rsp_cause`, `rsp_stat`, `rsp_fast`, `bad_addr` and `pte_vpn` unchanged.
- R12: Encodings used throughout:
  - `req_kind`: 0 = load, 1 = store, 2 = fetch, 3 = treated as a load;
  - `rsp_stat` bits: bit 0 = D, bit 1 = PERM, bit 2 = BAD, bit 3 = DBL, bit 4 = WE;
  - cause 0 = none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address of the access |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_misal | input | 1 | Access is misaligned |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_r | input | 1 | Read right of the hit entry |
| tlb_w | input | 1 | Write right of the hit entry |
| tlb_x | input | 1 | Execute right of the hit entry |
| mmu_en | input | 1 | An MMU is fitted |
| eh_in | input | 1 | Exception-handling bit of the status word |
| rsp_valid | output | 1 | Results for last cycle's request |
| rsp_ok | output | 1 | Access allowed |
| rsp_bypass | output | 1 | Address maps one-to-one |
| rsp_cause | output | 4 | Cause code, 0 when allowed |
| rsp_stat | output | 5 | Fault-status bits to set |
| rsp_fast | output | 1 | 1 = fast TLB-miss vector, 0 = general vector |
| bad_addr | output | 32 | Address of the last faulting access |
| pte_vpn | output | 20 | Page number of the last translation fault |

## Verification
Every result of a request is due on the first clock edge after the strobe, and no result appears earlier or later. The bench model updates its expected state on that same edge from the inputs it drove. It then compares every output half a period later, on the falling edge, in every cycle, including idle cycles, where the expected values are the held ones. The bad-address and page-number registers are compared in every cycle too, so any load on a wrong fault kind or on an idle cycle shows up at the edge where it happens.

// File: rtl/mmu_fault_sel.sv
module mmu_fault_sel #(
  parameter int          PAGE_BITS = 12,
  parameter logic [31:0] USER_TOP  = 32'h8000_0000,
  parameter logic [31:0] KERN_WIN  = 32'hC000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [31:0]           req_addr,
  input  logic [1:0]            req_kind,
  input  logic                  req_user,
  input  logic                  req_misal,
  input  logic                  tlb_hit,
  input  logic                  tlb_r,
  input  logic                  tlb_w,
  input  logic                  tlb_x,
  input  logic                  mmu_en,
  input  logic                  eh_in,
  output logic                  rsp_valid,
  output logic                  rsp_ok,
  output logic                  rsp_bypass,
  output logic [3:0]            rsp_cause,
  output logic [4:0]            rsp_stat,
  output logic                  rsp_fast,
  output logic [31:0]           bad_addr,
  output logic [31-PAGE_BITS:0] pte_vpn
);
  localparam int VPN_W = 32 - PAGE_BITS;
  localparam int S_D = 0, S_PERM = 1, S_BAD = 2, S_DBL = 3, S_WE = 4;
  localparam logic [3:0] C_NONE = 4'd0, C_MISS_I = 4'd1, C_MISS_D = 4'd2,
                         C_PERM_R = 4'd3, C_PERM_W = 4'd4, C_PERM_X = 4'd5,
                         C_SUPA_I = 4'd6, C_SUPA_D = 4'd7, C_MISAL = 4'd8;

  wire is_fetch = (req_kind == 2'd2);
  wire is_store = (req_kind == 2'd1);
  wire right_ok = is_fetch ? tlb_x : (is_store ? tlb_w : tlb_r);
  wire kern_win = !req_user && (req_addr >= KERN_WIN);
  wire user_bad = req_user && (req_addr >= USER_TOP);

  logic       n_ok, n_byp, n_fast, n_xlat;
  logic [3:0] n_cause;
  logic [4:0] n_stat;

  always_comb begin
    n_ok    = 1'b0;
    n_byp   = 1'b0;
    n_fast  = 1'b0;
    n_xlat  = 1'b0;
    n_cause = C_NONE;
    n_stat  = '0;
    if (req_misal) begin
      n_cause       = C_MISAL;
      n_stat[S_BAD] = 1'b1;
      n_stat[S_D]   = !is_fetch;
    end else if (!mmu_en || kern_win) begin
      n_ok  = 1'b1;
      n_byp = 1'b1;
    end else if (user_bad) begin
      n_cause       = is_fetch ? C_SUPA_I : C_SUPA_D;
      n_stat[S_BAD] = 1'b1;
      n_stat[S_D]   = !is_fetch;
    end else if (!tlb_hit) begin
      n_xlat        = 1'b1;
      n_cause       = is_fetch ? C_MISS_I : C_MISS_D;
      n_stat[S_D]   = !is_fetch;
      n_stat[S_DBL] = eh_in;
      n_stat[S_WE]  = !eh_in;
      n_fast        = !eh_in;
    end else if (!right_ok) begin
      n_xlat         = 1'b1;
      n_cause        = is_fetch ? C_PERM_X : (is_store ? C_PERM_W : C_PERM_R);
      n_stat[S_PERM] = 1'b1;
      n_stat[S_D]    = !is_fetch;
      n_stat[S_WE]   = !eh_in;
    end else begin
      n_ok = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_bypass <= 1'b0;
      rsp_cause  <= C_NONE;
      rsp_stat   <= '0;
      rsp_fast   <= 1'b0;
      bad_addr   <= '0;
      pte_vpn    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok     <= n_ok;
        rsp_bypass <= n_byp;
        rsp_cause  <= n_cause;
        rsp_stat   <= n_stat;
        rsp_fast   <= n_fast;
        if (!n_ok) bad_addr <= req_addr;
        if (n_xlat) pte_vpn <= req_addr[31:PAGE_BITS];
      end
    end
  end

  logic unused_w;
  assign unused_w = (VPN_W == 0);
endmodule

module mmu_fault_sel_chk #(
  parameter int PAGE_BITS = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  rsp_valid,
  input logic                  rsp_ok,
  input logic                  rsp_bypass,
  input logic [3:0]            rsp_cause,
  input logic [4:0]            rsp_stat,
  input logic                  rsp_fast,
  input logic [31:0]           bad_addr,
  input logic [31-PAGE_BITS:0] pte_vpn
);
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |-> (rsp_cause == 4'd0 && rsp_stat == 5'd0 && !rsp_fast));
  a_r3_bypass_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bypass) |-> rsp_ok);
  a_r7_fast_only_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fast) |-> ((rsp_cause == 4'd1 || rsp_cause == 4'd2)
                                 && rsp_stat[4] && !rsp_stat[3]));
  a_r8_vpn_of_badaddr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause >= 4'd1 && rsp_cause <= 4'd5)
      |-> (pte_vpn == bad_addr[31:PAGE_BITS]));
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_cause) && $stable(rsp_stat) && $stable(bad_addr)
                    && $stable(pte_vpn)));
  a_r12_stat_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_stat[3:1]) <= 1));
endmodule

bind mmu_fault_sel mmu_fault_sel_chk #(.PAGE_BITS(PAGE_BITS)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .rsp_bypass(rsp_bypass), .rsp_cause(rsp_cause),
  .rsp_stat(rsp_stat), .rsp_fast(rsp_fast), .bad_addr(bad_addr),
  .pte_vpn(pte_vpn)
);

// File: tb/tb_mmu_fault_sel.sv
`timescale 1ns/1ps
module tb_mmu_fault_sel;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_user = 0, req_misal = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] req_kind = 0;
  logic tlb_hit = 0, tlb_r = 0, tlb_w = 0, tlb_x = 0, mmu_en = 0, eh_in = 0;
  logic rsp_valid, rsp_ok, rsp_bypass, rsp_fast;
  logic [3:0] rsp_cause;
  logic [4:0] rsp_stat;
  logic [31:0] bad_addr;
  logic [19:0] pte_vpn;

  always #2.5 clk = ~clk;

  mmu_fault_sel dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // reference state
  int e_valid = 0, e_ok = 0, e_byp = 0, e_cause = 0, e_stat = 0, e_fast = 0;
  longint e_bad = 0, e_vpn = 0;
  string e_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e_ok = 0; e_byp = 0; e_cause = 0; e_stat = 0; e_fast = 0;
      e_bad = 0; e_vpn = 0; e_tag = "R1";
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        int dflag, fetch, need;
        fetch = (req_kind == 2);
        dflag = fetch ? 0 : 1;
        need = fetch ? tlb_x : (req_kind == 1 ? tlb_w : tlb_r);
        e_ok = 0; e_byp = 0; e_fast = 0; e_stat = 0; e_cause = 0;
        if (req_misal) begin
          e_tag = "R9"; e_cause = 8; e_stat = 4 + dflag; e_bad = req_addr;
        end else if (!mmu_en) begin
          e_tag = "R3"; e_ok = 1; e_byp = 1;
        end else if (!req_user && req_addr >= 32'hC000_0000) begin
          e_tag = "R4"; e_ok = 1; e_byp = 1;
        end else if (req_user && req_addr >= 32'h8000_0000) begin
          e_tag = "R5"; e_cause = fetch ? 6 : 7; e_stat = 4 + dflag; e_bad = req_addr;
        end else if (!tlb_hit) begin
          e_tag = "R7"; e_cause = fetch ? 1 : 2;
          e_stat = dflag + (eh_in ? 8 : 16); e_fast = eh_in ? 0 : 1;
          e_bad = req_addr; e_vpn = req_addr / 4096;
        end else if (!need) begin
          e_tag = "R6"; e_cause = fetch ? 5 : (req_kind == 1 ? 4 : 3);
          e_stat = dflag + 2 + (eh_in ? 0 : 16);
          e_bad = req_addr; e_vpn = req_addr / 4096;
        end else begin
          e_tag = "R10"; e_ok = 1;
        end
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string t;
      t = e_valid ? e_tag : "R11";
      chk("R2", "rsp_valid", rsp_valid, e_valid);
      chk(t, "rsp_ok", rsp_ok, e_ok);
      chk(t, "rsp_bypass", rsp_bypass, e_byp);
      chk(t, "rsp_cause", rsp_cause, e_cause);
      chk(t, "rsp_stat", rsp_stat, e_stat);
      chk(t, "rsp_fast", rsp_fast, e_fast);
      chk("R8", "bad_addr", bad_addr, e_bad);
      chk("R8", "pte_vpn", pte_vpn, e_vpn);
    end
  end

  task automatic req(logic [31:0] a, logic [1:0] k, logic u, logic m,
                     logic h, logic [2:0] rwx, logic en, logic eh);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_kind = k; req_user = u; req_misal = m;
    tlb_hit = h; tlb_r = rwx[2]; tlb_w = rwx[1]; tlb_x = rwx[0];
    mmu_en = en; eh_in = eh;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; req_addr = $urandom; tlb_hit = $urandom;
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero under reset
    chk("R1", "reset rsp_valid", rsp_valid, 0);
    chk("R1", "reset cause", rsp_cause, 0);
    chk("R1", "reset bad_addr", bad_addr, 0);
    rst_n = 1;
    idle(2);
    // R3 no MMU
    req(32'h1234_5678, 0, 1, 0, 0, 3'b000, 0, 0);
    req(32'hF000_0000, 2, 1, 0, 0, 3'b000, 0, 1);
    // R4 kernel window
    req(32'hC000_0000, 1, 0, 0, 0, 3'b000, 1, 0);
    req(32'hFFFF_FFFC, 2, 0, 0, 1, 3'b000, 1, 1);
    // supervisor just below window uses TLB (R10 / R7)
    req(32'hBFFF_F000, 0, 0, 0, 1, 3'b100, 1, 0);
    req(32'hBFFF_E000, 0, 0, 0, 0, 3'b111, 1, 0);
    // R5 user protected window
    req(32'h8000_0000, 2, 1, 0, 1, 3'b111, 1, 0);
    req(32'h9ABC_D004, 1, 1, 0, 1, 3'b111, 1, 1);
    req(32'h7FFF_FFF0, 0, 1, 0, 1, 3'b100, 1, 0);
    idle(3);
    // R6 permission faults, EH both ways
    req(32'h0000_3000, 0, 1, 0, 1, 3'b011, 1, 0);
    req(32'h0004_5000, 1, 1, 0, 1, 3'b101, 1, 1);
    req(32'h0067_8008, 2, 0, 0, 1, 3'b110, 1, 0);
    req(32'h0067_8008, 3, 0, 0, 1, 3'b011, 1, 1);
    // R7 misses, fast and double
    req(32'h1111_2222, 2, 1, 0, 0, 3'b111, 1, 0);
    req(32'h3333_4444, 0, 1, 0, 0, 3'b111, 1, 1);
    req(32'h5555_6666, 1, 0, 0, 0, 3'b111, 1, 0);
    idle(2);
    // R9 misalignment priority
    req(32'hC000_0002, 0, 0, 1, 1, 3'b111, 1, 0);
    req(32'h8000_0001, 2, 1, 1, 0, 3'b000, 1, 0);
    req(32'h0000_0003, 1, 1, 1, 0, 3'b000, 0, 0);
    // R10 allowed hits
    req(32'h0001_0000, 1, 1, 0, 1, 3'b010, 1, 1);
    req(32'h0001_0004, 2, 1, 0, 1, 3'b001, 1, 0);
    idle(4);
    // mixed stimulus with idle gaps
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = $urandom;
      req(a, 2'($urandom), 1'($urandom), ($urandom % 8) == 0, 1'($urandom),
          3'($urandom), ($urandom % 6) != 0, 1'($urandom));
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(3);
    finish_up();
  end
endmodule